// File: doc/BRIEF.md
# Access-Mode Register Bank with AXI4-Lite Slave

This block is a small register file reached through an AXI4-Lite slave port. Each register has a fixed access mode: read-only registers show the value of an input port, write-only registers drive an output port and read back as zero, and read-write registers drive an output port and read back their current value. A wide signal that does not fit in one 32-bit word is spread over two consecutive word slots, low word first. Registers narrower than a word read with their unused upper bits at zero.

The register map sits at the `BASE_ADDR` parameter. The status word is at offset 0x00, control at 0x04, command at 0x08, the wide word pair at 0x0C and 0x10, and the count word at 0x14. Every other address gets a SLVERR response. This covers offsets 0x18 and above, addresses below the base, and addresses that are not a multiple of four. Status and count are read-only. Control is read-write. Command is write-only. The wide register is read-write, with a width of 33 to 64 bits.

There are three strobe outputs, each one clock long. One marks a read of the status word, one marks a write of the control word, and one marks a write of the command word. The write address and the write data can arrive in either order. The read channel runs on its own, independent of the write channel. The protection inputs are accepted and otherwise ignored.

Top module: `axreg_bank`

## Requirements
- R1: Reset is synchronous and active-low. While `rst_n` is sampled low, AWREADY, WREADY, ARREADY, BVALID and RVALID are all low. On the first clock after release, AWREADY, WREADY and ARREADY are high. Writable registers load their defaults from reset: control `CTRL_RST` (0xA5A50001), command `CMD_RST` (0) and wide `WIDE_RST` (0x00C300000042).
- R2: Each slot is decoded at `BASE_ADDR` plus its offset: status 0x00, control 0x04, command 0x08, wide low word 0x0C, wide high word 0x10, count 0x14.
- R3: A read of status or count returns the input port value as sampled on the clock that accepts the read address, with unused upper bits at zero. A write to either of these addresses completes with OKAY (2'b00) and changes no output and no register.
- R4: A read of the command address returns 0x00000000 with OKAY. A write to it updates `cmd_o`.
- R5: A read of the control address returns the current value of `ctrl_o`. A write to it updates `ctrl_o`.
- R6: A write changes only the byte lanes selected by WSTRB. WSTRB bit i selects data bits 8i+7..8i. All other bits keep their value.
- R7: The wide register's bits 31..0 are at 0x0C and its bits WIDE_W-1..32 are at 0x10, right-aligned, with unused upper bits reading zero. A write to one slot leaves the other slot's bits unchanged.
- R8: An access to an unaligned address, to offset 0x18 or above, or to an address below the base completes with SLVERR (2'b10), changes no register and pulses no strobe. A read with SLVERR returns data 0. Accesses to decoded slots return OKAY.
- R9: The write address and the write data are accepted in either order or together. BVALID stays low until both have been accepted.
- R10: Once BVALID or RVALID is high, it stays high with a stable response and data until the matching READY is sampled high. There is no limit on the wait.
- R11: `stat_rd_stb_o` pulses for exactly one clock on each OKAY read of the status slot. `ctrl_wr_stb_o` and `cmd_wr_stb_o` each pulse for one clock, on the clock BVALID rises, for each OKAY write to their own slot. No other access produces a pulse.
- R12: A read and a write can be in progress at the same time without affecting each other. On the clock after a response handshake, the matching READY outputs are high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awprot | input | 3 | Write protection attribute, accepted and ignored |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte-lane enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arprot | input | 3 | Read protection attribute, accepted and ignored |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| stat_i | input | STAT_W | Read-only status value |
| cnt_i | input | CNT_W | Read-only count value |
| stat_rd_stb_o | output | 1 | One-clock pulse on a status read |
| ctrl_o | output | CTRL_W | Control register value |
| ctrl_wr_stb_o | output | 1 | One-clock pulse on a control write |
| cmd_o | output | CMD_W | Command register value |
| cmd_wr_stb_o | output | 1 | One-clock pulse on a command write |
| wide_o | output | WIDE_W | Wide register value |

## Verification
The bench applies each write with the address first, the data first, or both together. It checks that the response never appears early. A design that fired on the first beat alone would write with stale data or raise BVALID too soon. It holds READY low for random stretches and checks the response for stability, which catches a design that drops or changes a response it is still presenting. It also sends narrow WSTRB patterns, writes to each half of the wide register, and writes to read-only addresses. A wrong design would clobber unselected bytes, the other word of the wide register, or state behind a read-only slot. Unaligned, out-of-window and below-base addresses must return SLVERR with no update and no strobe, and the strobe counts are compared against the accepted accesses.

// File: rtl/axreg_pkg.sv
package axreg_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned NSLOT  = 6;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10,
    RSP_DECERR = 2'b11
  } resp_e;

  // Word slots in address order; the wide register needs two neighbours.
  typedef enum logic [2:0] {
    SL_STAT  = 3'd0,
    SL_CTRL  = 3'd1,
    SL_CMD   = 3'd2,
    SL_WIDE0 = 3'd3,
    SL_WIDE1 = 3'd4,
    SL_CNT   = 3'd5
  } slot_e;

  // Replace the enabled byte lanes of cur with those of upd.
  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] upd,
    input logic [LANES-1:0]  be
  );
    logic [WORD_W-1:0] res;
    res = cur;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) res[i*8 +: 8] = upd[i*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/axreg_decode.sv
module axreg_decode
  import axreg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output slot_e             slot
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NSLOT * 4);

  logic [ADDR_W-1:0] off;

  // Addresses below the base wrap to a large offset and miss the window.
  assign off  = addr - BASE_ADDR;
  assign hit  = (off[1:0] == 2'b00) && (off < SPAN);
  assign slot = slot_e'(off[4:2]);
endmodule

// File: rtl/axreg_wr_chan.sv
module axreg_wr_chan
  import axreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic              wr_ok,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_strb,
  output logic              wr_fire
);
  logic aw_full_q, aw_full_d, w_full_q, w_full_d;
  logic aw_rdy_q, w_rdy_q, bvalid_q, bvalid_d;
  logic [1:0] bresp_q, bresp_d;
  logic aw_take, w_take;

  assign aw_take = awvalid & aw_rdy_q;
  assign w_take  = wvalid & w_rdy_q;
  assign wr_fire = aw_full_q & w_full_q & ~bvalid_q;

  always_comb begin
    aw_full_d = aw_full_q;
    w_full_d  = w_full_q;
    bvalid_d  = bvalid_q;
    bresp_d   = bresp_q;
    if (aw_take) aw_full_d = 1'b1;
    if (w_take)  w_full_d  = 1'b1;
    if (wr_fire) begin
      bvalid_d = 1'b1;
      bresp_d  = wr_ok ? RSP_OKAY : RSP_SLVERR;
    end
    if (bvalid_q && bready) begin
      bvalid_d  = 1'b0;
      aw_full_d = 1'b0;
      w_full_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      aw_rdy_q  <= 1'b0;
      w_rdy_q   <= 1'b0;
      bvalid_q  <= 1'b0;
      bresp_q   <= RSP_OKAY;
    end else begin
      aw_full_q <= aw_full_d;
      w_full_q  <= w_full_d;
      aw_rdy_q  <= ~aw_full_d;
      w_rdy_q   <= ~w_full_d;
      bvalid_q  <= bvalid_d;
      bresp_q   <= bresp_d;
    end
  end

  // Payload holders: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (aw_take) wr_addr <= awaddr;
    if (w_take) begin
      wr_data <= wdata;
      wr_strb <= wstrb;
    end
  end

  assign awready = aw_rdy_q;
  assign wready  = w_rdy_q;
  assign bvalid  = bvalid_q;
  assign bresp   = bresp_q;
endmodule

// File: rtl/axreg_rd_chan.sv
module axreg_rd_chan
  import axreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  output logic [WORD_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic              rd_ok,
  input  logic [WORD_W-1:0] rd_word,
  output logic              rd_accept
);
  logic ar_rdy_q, rvalid_q, rvalid_d;
  logic [1:0] rresp_q, rresp_d;

  assign rd_accept = arvalid & ar_rdy_q;

  always_comb begin
    rvalid_d = rvalid_q;
    rresp_d  = rresp_q;
    if (rd_accept) begin
      rvalid_d = 1'b1;
      rresp_d  = rd_ok ? RSP_OKAY : RSP_SLVERR;
    end
    if (rvalid_q && rready) rvalid_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_rdy_q <= 1'b0;
      rvalid_q <= 1'b0;
      rresp_q  <= RSP_OKAY;
    end else begin
      ar_rdy_q <= ~rvalid_d;
      rvalid_q <= rvalid_d;
      rresp_q  <= rresp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_accept) rdata <= rd_ok ? rd_word : '0;
  end

  assign arready = ar_rdy_q;
  assign rvalid  = rvalid_q;
  assign rresp   = rresp_q;
endmodule

// File: rtl/axreg_bank.sv
module axreg_bank
  import axreg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400,
  parameter int unsigned       STAT_W    = 32,
  parameter int unsigned       CTRL_W    = 32,
  parameter int unsigned       CMD_W     = 16,
  parameter int unsigned       WIDE_W    = 48,
  parameter int unsigned       CNT_W     = 8,
  parameter logic [CTRL_W-1:0] CTRL_RST  = 32'hA5A5_0001,
  parameter logic [CMD_W-1:0]  CMD_RST   = '0,
  parameter logic [WIDE_W-1:0] WIDE_RST  = 48'h00C3_0000_0042
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [2:0]        s_awprot,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [2:0]        s_arprot,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              stat_rd_stb_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ctrl_wr_stb_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              cmd_wr_stb_o,
  output logic [WIDE_W-1:0] wide_o
);
  localparam int unsigned WIDE_SLOTS = (WIDE_W + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W      = WIDE_SLOTS * WORD_W;

  logic              unused_prot;
  logic              wr_fire, wr_hit, wr_en, rd_accept, rd_hit;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data, rd_word, sel_word, merged;
  logic [LANES-1:0]  wr_strb;
  slot_e             wr_slot, rd_slot;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [WIDE_W-1:0] wide_q, wide_d;
  logic [PAD_W-1:0]  wide_ext, wide_nx;
  logic              stat_stb_q, ctrl_stb_q, cmd_stb_q;

  assign unused_prot = ^{s_awprot, s_arprot};

  axreg_wr_chan #(.ADDR_W(ADDR_W)) wr_chan_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .awaddr  (s_awaddr),
    .awvalid (s_awvalid),
    .awready (s_awready),
    .wdata   (s_wdata),
    .wstrb   (s_wstrb),
    .wvalid  (s_wvalid),
    .wready  (s_wready),
    .bresp   (s_bresp),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .wr_ok   (wr_hit),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_strb (wr_strb),
    .wr_fire (wr_fire)
  );

  axreg_rd_chan rd_chan_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arvalid   (s_arvalid),
    .arready   (s_arready),
    .rdata     (s_rdata),
    .rresp     (s_rresp),
    .rvalid    (s_rvalid),
    .rready    (s_rready),
    .rd_ok     (rd_hit),
    .rd_word   (rd_word),
    .rd_accept (rd_accept)
  );

  axreg_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) wr_dec_i (
    .addr (wr_addr),
    .hit  (wr_hit),
    .slot (wr_slot)
  );

  axreg_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) rd_dec_i (
    .addr (s_araddr),
    .hit  (rd_hit),
    .slot (rd_slot)
  );

  assign wide_ext = PAD_W'(wide_q);
  assign wr_en    = wr_fire & wr_hit;

  // Current word behind the write slot, merged with the enabled lanes.
  always_comb begin
    sel_word = '0;
    for (int g = 0; g < WIDE_SLOTS; g++) begin
      if (wr_slot == slot_e'(SL_WIDE0 + g)) sel_word = wide_ext[g*WORD_W +: WORD_W];
    end
    if (wr_slot == SL_CTRL) sel_word = WORD_W'(ctrl_q);
    if (wr_slot == SL_CMD)  sel_word = WORD_W'(cmd_q);
    merged = lane_merge(sel_word, wr_data, wr_strb);
  end

  // Next-state of the writable registers.
  always_comb begin
    ctrl_d  = ctrl_q;
    cmd_d   = cmd_q;
    wide_nx = wide_ext;
    if (wr_en) begin
      if (wr_slot == SL_CTRL) ctrl_d = CTRL_W'(merged);
      if (wr_slot == SL_CMD)  cmd_d  = CMD_W'(merged);
      for (int g = 0; g < WIDE_SLOTS; g++) begin
        if (wr_slot == slot_e'(SL_WIDE0 + g)) wide_nx[g*WORD_W +: WORD_W] = merged;
      end
    end
    wide_d = WIDE_W'(wide_nx);
  end

  // Read word for the slot being accepted; write-only reads zero.
  always_comb begin
    rd_word = '0;
    case (rd_slot)
      SL_STAT:  rd_word = WORD_W'(stat_i);
      SL_CTRL:  rd_word = WORD_W'(ctrl_q);
      SL_CMD:   rd_word = '0;
      SL_WIDE0: rd_word = wide_ext[0 +: WORD_W];
      SL_WIDE1: rd_word = wide_ext[WORD_W +: WORD_W];
      SL_CNT:   rd_word = WORD_W'(cnt_i);
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RST;
      cmd_q      <= CMD_RST;
      wide_q     <= WIDE_RST;
      stat_stb_q <= 1'b0;
      ctrl_stb_q <= 1'b0;
      cmd_stb_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        ctrl_q <= ctrl_d;
        cmd_q  <= cmd_d;
        wide_q <= wide_d;
      end
      stat_stb_q <= rd_accept & rd_hit & (rd_slot == SL_STAT);
      ctrl_stb_q <= wr_en & (wr_slot == SL_CTRL);
      cmd_stb_q  <= wr_en & (wr_slot == SL_CMD);
    end
  end

  assign ctrl_o        = ctrl_q;
  assign cmd_o         = cmd_q;
  assign wide_o        = wide_q;
  assign stat_rd_stb_o = stat_stb_q;
  assign ctrl_wr_stb_o = ctrl_stb_q;
  assign cmd_wr_stb_o  = cmd_stb_q;
endmodule

// File: rtl/axreg_bank_chk.sv
module axreg_bank_chk #(
  parameter int unsigned CTRL_W = 32,
  parameter int unsigned CMD_W  = 16,
  parameter int unsigned WIDE_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awready,
  input logic              s_wready,
  input logic              s_arready,
  input logic              s_arvalid,
  input logic [1:0]        s_bresp,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [31:0]       s_rdata,
  input logic [1:0]        s_rresp,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic              stat_rd_stb_o,
  input logic              ctrl_wr_stb_o,
  input logic              cmd_wr_stb_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [WIDE_W-1:0] wide_o
);
  logic rst_low_q;
  always_ff @(posedge clk) rst_low_q <= !rst_n;

  always @(negedge clk) begin
    if (rst_low_q && !rst_n)
      AST_RESET_QUIET: assert (!s_awready && !s_wready && !s_arready && !s_bvalid && !s_rvalid); // R1
  end

  AST_B_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bvalid) |-> (!s_awready && !s_wready)); // R9

  AST_R_AFTER_AR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_rvalid) |-> $past(s_arvalid && s_arready)); // R12

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp))); // R10

  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp))); // R10

  AST_STAT_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_stb_o |=> !stat_rd_stb_o); // R11

  AST_CTRL_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_stb_o |=> !ctrl_wr_stb_o); // R11

  AST_WR_STB_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_stb_o || cmd_wr_stb_o) |-> ($rose(s_bvalid) && s_bresp == 2'b00)); // R11

  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> $rose(s_bvalid)); // R5

  AST_CMD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |-> $rose(s_bvalid)); // R4

  AST_WIDE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide_o) |-> ($rose(s_bvalid) && s_bresp == 2'b00)); // R7
endmodule

bind axreg_bank axreg_bank_chk #(
  .CTRL_W (CTRL_W),
  .CMD_W  (CMD_W),
  .WIDE_W (WIDE_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .s_awready     (s_awready),
  .s_wready      (s_wready),
  .s_arready     (s_arready),
  .s_arvalid     (s_arvalid),
  .s_bresp       (s_bresp),
  .s_bvalid      (s_bvalid),
  .s_bready      (s_bready),
  .s_rdata       (s_rdata),
  .s_rresp       (s_rresp),
  .s_rvalid      (s_rvalid),
  .s_rready      (s_rready),
  .stat_rd_stb_o (stat_rd_stb_o),
  .ctrl_wr_stb_o (ctrl_wr_stb_o),
  .cmd_wr_stb_o  (cmd_wr_stb_o),
  .ctrl_o        (ctrl_o),
  .cmd_o         (cmd_o),
  .wide_o        (wide_o)
);

// File: tb/axreg_bank_tb_top.sv
`timescale 1ns/1ps
module axreg_bank_tb_top;
  localparam logic [15:0] BASE = 16'h0400;
  localparam logic [31:0] CTRL_DEF = 32'hA5A5_0001;
  localparam logic [47:0] WIDE_DEF = 48'h00C3_0000_0042;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] awaddr, araddr;
  logic [2:0]  awprot, arprot;
  logic        awvalid, awready, wvalid, wready, bvalid, bready;
  logic        arvalid, arready, rvalid, rready;
  logic [31:0] wdata, rdata;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;
  logic [31:0] stat_v;
  logic [7:0]  cnt_v;
  logic        stat_stb, ctrl_stb, cmd_stb;
  logic [31:0] ctrl_o;
  logic [15:0] cmd_o;
  logic [47:0] wide_o;

  int checks = 0, fails = 0;
  int n_stat = 0, n_ctrl = 0, n_cmd = 0;
  int e_stat = 0, e_ctrl = 0, e_cmd = 0;
  logic [31:0] m_ctrl;
  logic [15:0] m_cmd;
  logic [47:0] m_wide;

  always #4 clk = ~clk;

  axreg_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awprot(awprot), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arprot(arprot), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .stat_i(stat_v), .cnt_i(cnt_v), .stat_rd_stb_o(stat_stb),
    .ctrl_o(ctrl_o), .ctrl_wr_stb_o(ctrl_stb), .cmd_o(cmd_o), .cmd_wr_stb_o(cmd_stb),
    .wide_o(wide_o)
  );

  always @(negedge clk) begin
    if (stat_stb) n_stat++;
    if (ctrl_stb) n_ctrl++;
    if (cmd_stb)  n_cmd++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Model of the map, built from the requirements.
  function automatic bit m_ok(input logic [15:0] a);
    logic [15:0] o;
    o = a - BASE;
    return (o[1:0] == 2'b00) && (o < 16'h0018);
  endfunction

  function automatic logic [31:0] m_rd(input logic [15:0] a);
    if (!m_ok(a)) return 32'h0;
    case (a - BASE)
      16'h00:  return stat_v;
      16'h04:  return m_ctrl;
      16'h0C:  return m_wide[31:0];
      16'h10:  return {16'h0, m_wide[47:32]};
      16'h14:  return {24'h0, cnt_v};
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
    for (int b = 0; b < 4; b++) begin
      if (s[b]) begin
        case (a - BASE)
          16'h04: m_ctrl[8*b +: 8] = d[8*b +: 8];
          16'h08: if (b < 2) m_cmd[8*b +: 8] = d[8*b +: 8];
          16'h0C: m_wide[8*b +: 8] = d[8*b +: 8];
          16'h10: if (b < 2) m_wide[32 + 8*b +: 8] = d[8*b +: 8];
          default: ;
        endcase
      end
    end
  endtask

  task automatic check_outs(input string req);
    chk(ctrl_o == m_ctrl, {req, " ctrl_o"}, 64'(ctrl_o), 64'(m_ctrl));
    chk(cmd_o == m_cmd, {req, " cmd_o"}, 64'(cmd_o), 64'(m_cmd));
    chk(wide_o == m_wide, {req, " wide_o"}, 64'(wide_o), 64'(m_wide));
  endtask

  task automatic check_stb(input string req);
    chk(n_stat == e_stat, {req, " status read strobe count"}, 64'(n_stat), 64'(e_stat));
    chk(n_ctrl == e_ctrl, {req, " control write strobe count"}, 64'(n_ctrl), 64'(e_ctrl));
    chk(n_cmd == e_cmd, {req, " command write strobe count"}, 64'(n_cmd), 64'(e_cmd));
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order, input int bdly);
    bit aw_done = 0, w_done = 0, aw_pend = 0, w_pend = 0, aw_on, w_on;
    logic [1:0] exp_resp, first_resp;
    forever begin
      @(negedge clk);
      if (aw_pend) aw_done = 1;
      if (w_pend) w_done = 1;
      if (aw_done && w_done) break;
      chk(bvalid == 1'b0, "R9 BVALID before both beats", 64'(bvalid), 64'd0);
      aw_on = !aw_done && (order != 2 || w_done);
      w_on  = !w_done && (order != 1 || aw_done);
      awvalid = aw_on; awaddr = a;
      wvalid = w_on; wdata = d; wstrb = s;
      aw_pend = aw_on && awready;
      w_pend  = w_on && wready;
    end
    awvalid = 0; wvalid = 0;
    while (!bvalid) @(negedge clk);
    first_resp = bresp;
    for (int i = 0; i < bdly; i++) begin
      @(negedge clk);
      chk(bvalid == 1'b1 && bresp == first_resp, "R10 write response held", 64'({bvalid, bresp}), 64'({1'b1, first_resp}));
    end
    exp_resp = m_ok(a) ? 2'b00 : 2'b10;
    chk(bresp == exp_resp, "R8 write response code", 64'(bresp), 64'(exp_resp));
    bready = 1;
    @(negedge clk);
    bready = 0;
    chk(awready && wready, "R12 write ready after handshake", 64'({awready, wready}), 64'd3);
    if (m_ok(a)) begin
      m_wr(a, d, s);
      if (a == BASE + 16'h04) e_ctrl++;
      if (a == BASE + 16'h08) e_cmd++;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int rdly);
    logic [31:0] exp_d, first_d;
    logic [1:0]  exp_resp;
    exp_d    = m_rd(a);
    exp_resp = m_ok(a) ? 2'b00 : 2'b10;
    @(negedge clk);
    arvalid = 1; araddr = a;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    while (!rvalid) @(negedge clk);
    first_d = rdata;
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      chk(rvalid == 1'b1 && rdata == first_d, "R10 read data held", 64'(rdata), 64'(first_d));
    end
    chk(rresp == exp_resp, "R8 read response code", 64'(rresp), 64'(exp_resp));
    chk(rdata == exp_d, "R2 read data for address", 64'(rdata), 64'(exp_d));
    rready = 1;
    @(negedge clk);
    rready = 0;
    chk(arready == 1'b1, "R12 read ready after handshake", 64'(arready), 64'd1);
    if (m_ok(a) && a == BASE) e_stat++;
  endtask

  function automatic logic [15:0] pick_addr(input int k);
    case (k)
      0, 1, 2, 3, 4, 5: return BASE + 16'(4 * k);
      6:       return BASE + 16'(4 * $urandom_range(0, 5)) + 16'($urandom_range(1, 3));
      7:       return BASE + 16'h0018;
      8:       return BASE + 16'h003C;
      default: return BASE - 16'h0004;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    void'($urandom(32'h0005_EED5));
    rst_n = 0; awvalid = 0; wvalid = 0; bready = 0; arvalid = 0; rready = 0;
    awaddr = '0; araddr = '0; wdata = '0; wstrb = '0; awprot = '0; arprot = '0;
    stat_v = 32'h1357_9BDF; cnt_v = 8'h5A;
    m_ctrl = CTRL_DEF; m_cmd = 16'h0; m_wide = WIDE_DEF;

    repeat (4) @(negedge clk);
    chk(!awready && !wready && !arready && !bvalid && !rvalid, "R1 handshake outputs low in reset",
        64'({awready, wready, arready, bvalid, rvalid}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(awready && wready && arready, "R1 ready after release", 64'({awready, wready, arready}), 64'd7);
    check_outs("R1 defaults");

    // Directed corner cases
    do_read(BASE + 16'h04, 0);          // R5 control default
    do_read(BASE + 16'h0C, 2);          // R7 low word default
    do_read(BASE + 16'h10, 0);          // R7 high word default
    do_read(BASE + 16'h08, 0);          // R4 write-only reads zero
    do_write(BASE + 16'h00, 32'hFFFF_FFFF, 4'hF, 0, 1); // R3 write to read-only
    check_outs("R3 read-only write ignored");
    do_write(BASE + 16'h14, 32'hFFFF_FFFF, 4'hF, 2, 0); // R3
    check_outs("R3 count write ignored");
    do_write(BASE + 16'h08, 32'hDEAD_1234, 4'hF, 1, 0); // R4 R9 address first
    check_outs("R4 command write");
    do_read(BASE + 16'h08, 0);          // R4
    do_write(BASE + 16'h04, 32'h1122_3344, 4'b0101, 2, 3); // R6 R9 data first
    check_outs("R6 byte lanes");
    do_write(BASE + 16'h10, 32'hCAFE_BEEF, 4'hF, 0, 0); // R7 high word only
    check_outs("R7 high word write");
    do_write(BASE + 16'h0C, 32'h0F0F_F0F0, 4'b1000, 1, 0); // R7 R6
    check_outs("R7 low word write");
    do_write(BASE + 16'h05, 32'h0, 4'hF, 0, 0);  // R8 unaligned
    do_write(BASE + 16'h18, 32'h0, 4'hF, 0, 0);  // R8 undefined offset
    do_write(BASE - 16'h04, 32'h0, 4'hF, 0, 0);  // R8 below base
    check_outs("R8 error writes ignored");
    do_read(BASE + 16'h06, 1);          // R8
    do_read(BASE + 16'h20, 0);          // R8
    stat_v = 32'h8000_0001; cnt_v = 8'hC3;
    do_read(BASE + 16'h00, 0);          // R3 R11 status
    do_read(BASE + 16'h14, 0);          // R3 count upper bits zero
    check_stb("R11 directed");

    // R12: read and write concurrently on different slots
    fork
      do_write(BASE + 16'h08, 32'h0000_7777, 4'h3, 0, 2);
      do_read(BASE + 16'h0C, 1);
    join
    check_outs("R12 concurrent");
    check_stb("R11 concurrent");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = pick_addr($urandom_range(0, 9));
      stat_v = $urandom(); cnt_v = 8'($urandom());
      if ($urandom_range(0, 1) == 0)
        do_write(a, $urandom(), 4'($urandom()), $urandom_range(0, 2), $urandom_range(0, 3));
      else
        do_read(a, $urandom_range(0, 3));
      check_outs("R5 random");
      check_stb("R11 random");
    end

    repeat (3) @(negedge clk);
    report();
  end
endmodule